// File: doc/BRIEF.md
# Scanline Border Decision Controller

This block times one video scanline at a time. A line counter runs through each line. At a few fixed decision cycles the block decides whether the display-enable window opens or closes. It takes those decisions from two CPU-writable mode registers. The frequency register holds the 50/60 Hz choice and an external-sync bit. The resolution register holds a high-resolution bit. The high-resolution bit has priority: when it is set, the line runs on 70 Hz monochrome timing whatever the frequency register holds. The block drives a display-enable output and a horizontal sync output with its output enable. At the end of each line it reports the length of that line.

Line cycle k means the cycle in which the line counter holds k. Cycle 0 is the first cycle after a wrap. A 2-bit power-up phase offset n moves every decision point by n cycles. At each point the frequency register is sampled in the decision cycle itself and the resolution register one cycle later. A CPU write reaches the decision logic in the cycle of the write strobe, without waiting for a later bus slot. A testbench or a system model can therefore reproduce how line lengths and border openings change with phase and with the exact cycle of a register write.

Top module: `scanline_border_ctrl`

## Requirements
- R1: While reset is asserted, disp_en_o, line_done_o and line_len_o are 0 and hsync_oe_o is 1.
- R2: The line mode follows a priority. Resolution bit 1 set selects 70 Hz. Otherwise frequency bit 1 selects 50 Hz when set and 60 Hz when clear. A line wraps after 224, 512 or 508 cycles respectively. The mode used for the wrap is the one in effect in the wrap cycle.
- R3: Left decision: frequency bit 1 is taken at cycle 56+n and resolution bit 1 at cycle 57+n. If the combined mode is not 70 Hz, disp_en_o is high from cycle 58+n.
- R4: 60 Hz right border: frequency is taken at cycle 184+n and resolution at 185+n. If the combined mode is 60 Hz, disp_en_o is low from cycle 186+n.
- R5: 50 Hz right border: frequency is taken at cycle 224+n and resolution at 225+n. If the combined mode is 50 Hz, disp_en_o is low from cycle 226+n.
- R6: If high resolution is in effect at the resolution half of a right-border decision, that decision is skipped. The window then stays open until a later decision closes it or the line ends.
- R7: The resolution value used at a decision is the one from the cycle after the frequency sample. A high-resolution bit that is set in the frequency-sample cycle and cleared in the next cycle does not skip the decision.
- R8: A write strobe takes effect in its own cycle. A frequency write in a frequency-sample cycle, or a resolution write in a resolution-sample cycle, is used by that decision.
- R9: Frequency bit 0 selects external sync. From the cycle after such a write, hsync_oe_o is 0 and hsync_o is held 0. Otherwise hsync_o is 1 during line cycles 0 to HS_LEN-1.
- R10: A line end forces disp_en_o low. In the first cycle of the next line, line_done_o pulses for one cycle and line_len_o holds the length of the line that just ended.
- R11: phase_i is captured only while reset is asserted. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line cycle per period |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 2 | Power-up phase offset, captured during reset |
| wr_freq_i | input | 1 | Write strobe for the frequency register |
| wr_res_i | input | 1 | Write strobe for the resolution register |
| wr_data_i | input | REG_W | Write data for either register |
| disp_en_o | output | 1 | Display-enable window |
| hsync_o | output | 1 | Internal horizontal sync, active high |
| hsync_oe_o | output | 1 | Sync output enable, low in external-sync mode |
| line_done_o | output | 1 | One-cycle pulse in the first cycle of a line |
| line_len_o | output | CNT_W | Length of the line that just ended |

## Verification
The properties take three things for granted. The two write strobes are never raised in the same cycle. phase_i is steady for the last cycles of reset. The decision points of the default geometry lie well inside the shortest low-resolution line, so no point can coincide with a wrap. The stimulus drives at most one strobe per cycle, holds phase_i for several reset cycles before changing it, and times every write by line position counted from the line_done_o pulse. In this way writes fall exactly on, just before or just after the sample cycles for each of the four phases.

// File: rtl/border_pkg.sv
package border_pkg;
   typedef enum logic [1:0] {
      MODE_60 = 2'd0,
      MODE_50 = 2'd1,
      MODE_70 = 2'd2
   } line_mode_e;

   // high resolution wins over the frequency choice
   function automatic line_mode_e mode_of(input logic freq50, input logic hires);
      if (hires)       return MODE_70;
      else if (freq50) return MODE_50;
      else             return MODE_60;
   endfunction
endpackage

// File: rtl/border_regs.sv
module border_regs #(
   parameter int REG_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_freq_i,
   input  logic             wr_res_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic             freq50_eff_o,
   output logic             hires_eff_o,
   output logic             ext_sync_o,
   output logic             hires_q_o
);
   logic [1:0] freq_q;
   logic       hires_q;

   if (REG_W < 2) begin : g_bad_width
      $error("border_regs: REG_W must be at least 2");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         freq_q  <= '0;
         hires_q <= 1'b0;
      end else begin
         if (wr_freq_i) freq_q  <= wr_data_i[1:0];
         if (wr_res_i)  hires_q <= wr_data_i[1];
      end
   end

   // write data bypasses the register so decisions see it in the strobe cycle
   assign freq50_eff_o = wr_freq_i ? wr_data_i[1] : freq_q[1];
   assign hires_eff_o  = wr_res_i  ? wr_data_i[1] : hires_q;
   assign ext_sync_o   = freq_q[0];
   assign hires_q_o    = hires_q;
endmodule

// File: rtl/line_timer.sv
module line_timer
   import border_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int LEN_50 = 512,
   parameter int LEN_60 = 508,
   parameter int LEN_70 = 224
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  line_mode_e       mode_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             done_o,
   output logic [CNT_W-1:0] len_o
);
   localparam int LEN_MAX = (LEN_50 > LEN_60) ? LEN_50 : LEN_60;

   if (LEN_MAX >= (1 << CNT_W) || LEN_70 < 2) begin : g_bad_len
      $error("line_timer: line lengths do not fit CNT_W");
   end

   logic [CNT_W-1:0] cnt_q, len_q;
   logic [CNT_W:0]   len_sel;
   logic             done_q;

   always_comb begin
      unique case (mode_i)
         MODE_70: len_sel = (CNT_W+1)'(LEN_70);
         MODE_50: len_sel = (CNT_W+1)'(LEN_50);
         default: len_sel = (CNT_W+1)'(LEN_60);
      endcase
   end

   // >= so a late switch to a shorter mode still ends the line at once
   assign wrap_o = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= len_sel;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         len_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= wrap_o;
         if (wrap_o) begin
            cnt_q <= '0;
            len_q <= cnt_q + CNT_W'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign done_o = done_q;
   assign len_o  = len_q;
endmodule

// File: rtl/border_decider.sv
module border_decider
   import border_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int LEFT_CYC = 56,
   parameter int R60_CYC  = 184,
   parameter int R50_CYC  = 224
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [1:0]       phase_i,
   input  logic             wrap_i,
   input  logic             freq50_i,
   input  logic             hires_i,
   output logic             de_o
);
   localparam int NPT = 3;
   localparam int PTS [NPT] = '{LEFT_CYC, R60_CYC, R50_CYC};

   logic [NPT-1:0] hit_f, hit_r;
   logic           freq_smp_q, de_q;
   line_mode_e     mode_c;

   for (genvar i = 0; i < NPT; i++) begin : g_pt
      // frequency half at point+n, resolution half one cycle later
      assign hit_f[i] = (cnt_i == CNT_W'(PTS[i]) + CNT_W'(phase_i));
      assign hit_r[i] = (cnt_i == CNT_W'(PTS[i] + 1) + CNT_W'(phase_i));
   end

   assign mode_c = mode_of(freq_smp_q, hires_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         freq_smp_q <= 1'b0;
         de_q       <= 1'b0;
      end else begin
         if (|hit_f) freq_smp_q <= freq50_i;
         if (wrap_i)                               de_q <= 1'b0;
         else if (hit_r[0] && mode_c != MODE_70)   de_q <= 1'b1;
         else if (hit_r[1] && mode_c == MODE_60)   de_q <= 1'b0;
         else if (hit_r[2] && mode_c == MODE_50)   de_q <= 1'b0;
      end
   end

   assign de_o = de_q;
endmodule

// File: rtl/sync_gen.sv
module sync_gen #(
   parameter int CNT_W      = 10,
   parameter int HS_LEN     = 40,
   parameter bit REGISTERED = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             ext_sync_i,
   output logic             hsync_o,
   output logic             hsync_oe_o
);
   logic hs_c;

   assign hs_c       = !ext_sync_i && (cnt_i < CNT_W'(HS_LEN));
   assign hsync_oe_o = !ext_sync_i;

   if (REGISTERED) begin : g_reg
      logic hs_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) hs_q <= 1'b0;
         else         hs_q <= hs_c && !ext_sync_i;
      end
      assign hsync_o = hs_q && !ext_sync_i;
   end else begin : g_comb
      assign hsync_o = hs_c;
   end
endmodule

// File: rtl/scanline_border_ctrl.sv
module scanline_border_ctrl
   import border_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int REG_W    = 2,
   parameter int LEN_50   = 512,
   parameter int LEN_60   = 508,
   parameter int LEN_70   = 224,
   parameter int LEFT_CYC = 56,
   parameter int R60_CYC  = 184,
   parameter int R50_CYC  = 224,
   parameter int HS_LEN   = 40,
   parameter bit HS_REG   = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       phase_i,
   input  logic             wr_freq_i,
   input  logic             wr_res_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic             disp_en_o,
   output logic             hsync_o,
   output logic             hsync_oe_o,
   output logic             line_done_o,
   output logic [CNT_W-1:0] line_len_o
);
   if (!(LEFT_CYC + 5 < R60_CYC && R60_CYC < R50_CYC && R50_CYC + 5 < LEN_60
         && LEFT_CYC + 5 < LEN_70)) begin : g_bad_points
      $error("scanline_border_ctrl: decision points out of order");
   end

   logic [1:0]       phase_q;
   logic             freq50_eff, hires_eff, ext_sync, hires_q, wrap;
   logic [CNT_W-1:0] cnt_q;
   line_mode_e       mode_now;

   // phase offset is latched while reset is held and frozen afterwards
   always_ff @(posedge clk_i) begin
      if (!rst_ni) phase_q <= phase_i;
   end

   border_regs #(.REG_W(REG_W)) regs_i (
      .clk_i, .rst_ni, .wr_freq_i, .wr_res_i, .wr_data_i,
      .freq50_eff_o(freq50_eff), .hires_eff_o(hires_eff),
      .ext_sync_o(ext_sync), .hires_q_o(hires_q)
   );

   assign mode_now = mode_of(freq50_eff, hires_eff);

   line_timer #(.CNT_W(CNT_W), .LEN_50(LEN_50), .LEN_60(LEN_60), .LEN_70(LEN_70)) timer_i (
      .clk_i, .rst_ni, .mode_i(mode_now), .cnt_o(cnt_q), .wrap_o(wrap),
      .done_o(line_done_o), .len_o(line_len_o)
   );

   border_decider #(.CNT_W(CNT_W), .LEFT_CYC(LEFT_CYC), .R60_CYC(R60_CYC),
                    .R50_CYC(R50_CYC)) decider_i (
      .clk_i, .rst_ni, .cnt_i(cnt_q), .phase_i(phase_q), .wrap_i(wrap),
      .freq50_i(freq50_eff), .hires_i(hires_eff), .de_o(disp_en_o)
   );

   sync_gen #(.CNT_W(CNT_W), .HS_LEN(HS_LEN), .REGISTERED(HS_REG)) sync_i (
      .clk_i, .rst_ni, .cnt_i(cnt_q), .ext_sync_i(ext_sync),
      .hsync_o, .hsync_oe_o
   );
endmodule

// File: rtl/border_ctrl_chk.sv
module border_ctrl_chk #(
   parameter int CNT_W    = 10,
   parameter int REG_W    = 2,
   parameter int LEN_50   = 512,
   parameter int LEN_60   = 508,
   parameter int LEN_70   = 224,
   parameter int LEFT_CYC = 56,
   parameter int R60_CYC  = 184,
   parameter int R50_CYC  = 224
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [1:0]       phase,
   input logic             hires_q,
   input logic             wr_freq,
   input logic             wr_res,
   input logic [REG_W-1:0] wr_data,
   input logic             de,
   input logic             hsync,
   input logic             hsync_oe,
   input logic             done,
   input logic [CNT_W-1:0] len
);
   logic hires_now;
   int   ph;
   assign hires_now = wr_res ? wr_data[1] : hires_q;
   assign ph        = int'(phase);

   // R3
   de_open_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de) |-> int'(cnt) == LEFT_CYC + ph + 2);

   // R4 R5 R10
   de_close_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(de) |-> (int'(cnt) == R60_CYC + ph + 2 || int'(cnt) == R50_CYC + ph + 2
                     || cnt == '0));

   // R6
   hires_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (de && hires_now && (int'(cnt) == R60_CYC + ph + 1 || int'(cnt) == R50_CYC + ph + 1))
      |=> de);

   // R2
   line_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(len) == LEN_50 || int'(len) == LEN_60 || int'(len) == LEN_70));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < LEN_50);

   // R9
   ext_sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_freq && wr_data[0]) |=> (!hsync_oe && !hsync));

   // R11
   phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(phase));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cnt == '0);
endmodule

bind scanline_border_ctrl border_ctrl_chk #(
   .CNT_W(CNT_W), .REG_W(REG_W), .LEN_50(LEN_50), .LEN_60(LEN_60), .LEN_70(LEN_70),
   .LEFT_CYC(LEFT_CYC), .R60_CYC(R60_CYC), .R50_CYC(R50_CYC)
) chk_i (
   .clk(clk_i), .rst_n(rst_ni), .cnt(cnt_q), .phase(phase_q), .hires_q(hires_q),
   .wr_freq(wr_freq_i), .wr_res(wr_res_i), .wr_data(wr_data_i), .de(disp_en_o),
   .hsync(hsync_o), .hsync_oe(hsync_oe_o), .done(line_done_o), .len(line_len_o)
);

// File: tb/scanline_border_ctrl_tb_top.sv
module scanline_border_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SEL_F = 0;
   localparam int SEL_R = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] phase = 2'd0;
   logic       wr_freq = 1'b0, wr_res = 1'b0;
   logic [1:0] wr_data = 2'd0;
   logic       de, hs, hs_oe, done;
   logic [9:0] len;

   always #(CLK_PERIOD/2) clk = ~clk;

   scanline_border_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .wr_freq_i(wr_freq),
      .wr_res_i(wr_res), .wr_data_i(wr_data), .disp_en_o(de), .hsync_o(hs),
      .hsync_oe_o(hs_oe), .line_done_o(done), .line_len_o(len)
   );

   typedef struct {
      string tag;
      int    open_c;
      int    close_c;
      int    len_c;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: measures each line and compares with the queued expectation
   bit mon_active = 1'b0;
   int mon_pos = 0, mon_open = 0, mon_close = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_active = 1'b0;
      end else if (done) begin
         if (mon_active) begin
            int   cl;
            exp_t e;
            cl = (mon_open != 0 && mon_close == 0) ? mon_pos + 1 : mon_close;
            if (q.size() == 0) begin
               chk(1'b0, "R10", "unexpected line end, queue size", 0, 1);
            end else begin
               e = q.pop_front();
               chk(mon_open == e.open_c, "R3", {e.tag, " open cycle"}, mon_open, e.open_c);
               chk(cl == e.close_c, e.tag, "close cycle", cl, e.close_c);
               chk(mon_pos + 1 == e.len_c, "R2", {e.tag, " measured length"}, mon_pos + 1, e.len_c);
               chk(int'(len) == e.len_c, "R10", {e.tag, " line_len_o"}, int'(len), e.len_c);
            end
         end
         mon_pos = 0; mon_open = 0; mon_close = 0; mon_active = 1'b1;
      end else if (mon_active) begin
         mon_pos++;
         if (de && mon_open == 0) mon_open = mon_pos;
         else if (!de && mon_open != 0 && mon_close == 0) mon_close = mon_pos;
      end
   end

   // driver: starts at a line-start negedge, returns at the next one
   task automatic run_line(input string tag, input int eo, input int ec, input int el,
                           input int c1, input int s1, input int d1,
                           input int c2, input int s2, input int d2);
      exp_t e;
      int   pos;
      e.tag = tag; e.open_c = eo; e.close_c = ec; e.len_c = el;
      q.push_back(e);
      pos = 0;
      forever begin
         @(negedge clk);
         wr_freq = 1'b0; wr_res = 1'b0; wr_data = 2'd0;
         if (done) break;
         pos++;
         if (pos == c1) begin
            if (s1 == SEL_F) wr_freq = 1'b1; else wr_res = 1'b1;
            wr_data = 2'(d1);
         end else if (pos == c2) begin
            if (s2 == SEL_F) wr_freq = 1'b1; else wr_res = 1'b1;
            wr_data = 2'(d2);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired, cycles", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int n = 0; n < 4; n++) begin
         rst_n = 1'b0; phase = 2'(n);
         repeat (4) @(negedge clk);
         // R1 reset state
         chk(de == 1'b0, "R1", "disp_en in reset", int'(de), 0);
         chk(done == 1'b0, "R1", "line_done in reset", int'(done), 0);
         chk(len == '0, "R1", "line_len in reset", int'(len), 0);
         chk(hs_oe == 1'b1, "R1", "hsync_oe in reset", int'(hs_oe), 1);
         rst_n = 1'b1;
         @(negedge clk);
         phase = 2'(n ^ 3);              // R11: must have no effect after reset
         do @(negedge clk); while (!done);

         run_line("R4",  58+n, 186+n, 508, -1, 0, 0, -1, 0, 0);
         run_line("R5",  58+n, 226+n, 512, 10, SEL_F, 2, -1, 0, 0);
         // R8: frequency back to 60 just after its sample at 184+n
         run_line("R8",  58+n, 508, 508, 185+n, SEL_F, 0, -1, 0, 0);
         // R8: frequency to 50 in the sample cycle itself
         run_line("R8",  58+n, 226+n, 512, 184+n, SEL_F, 2, -1, 0, 0);
         run_line("R4",  58+n, 186+n, 508, 10, SEL_F, 0, -1, 0, 0);
         run_line("R6",  58+n, 508, 508, 100, SEL_R, 2, 200, SEL_R, 0);
         // R8: resolution write in its own sample cycle skips the check
         run_line("R8",  58+n, 508, 508, 185+n, SEL_R, 2, 200, SEL_R, 0);
         // R7: high only during the frequency-sample cycle does not skip
         run_line("R7",  58+n, 186+n, 508, 184+n, SEL_R, 2, 185+n, SEL_R, 0);
         run_line("R6",  58+n, 186+n, 508, 186+n, SEL_R, 2, 200, SEL_R, 0);
         run_line("R2",  0, 0, 224, 10, SEL_R, 2, -1, 0, 0);
         run_line("R4",  58+n, 186+n, 508, 10, SEL_R, 0, -1, 0, 0);
         // R2 priority: high resolution overrides 50 Hz
         run_line("R2",  0, 0, 224, 10, SEL_F, 2, 20, SEL_R, 2);
         run_line("R5",  58+n, 226+n, 512, 10, SEL_R, 0, -1, 0, 0);
         run_line("R4",  58+n, 186+n, 508, 10, SEL_F, 0, -1, 0, 0);
         // R9 external sync on, then off
         run_line("R4",  58+n, 186+n, 508, 10, SEL_F, 1, -1, 0, 0);
         chk(hs_oe == 1'b0, "R9", "hsync_oe with external sync", int'(hs_oe), 0);
         chk(hs == 1'b0, "R9", "hsync with external sync", int'(hs), 0);
         run_line("R4",  58+n, 186+n, 508, 10, SEL_F, 0, -1, 0, 0);
         chk(hs_oe == 1'b1, "R9", "hsync_oe internal sync", int'(hs_oe), 1);
         chk(hs == 1'b1, "R9", "hsync at line cycle 0", int'(hs), 1);
         @(negedge clk);
         chk(q.size() == 0, "R10", "pending lines", q.size(), 0);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule